// File: doc/BRIEF.md
# One-Time Fuse Array Read Controller

This block sits behind a simple register bus and gives software access to a small one-time-programmable fuse array of sixteen-bit words. Software selects a block, issues a start command through a mode register, polls a status register until a sticky completion flag appears, collects the word from a data register, and then acknowledges completion with an explicit clear command. A separate module-enable bit gates every command. A start is accepted only while the controller reports standby.

The fuse array is modelled as a behavioural synchronous memory with a power-up pattern. The sample point of a read is set by a read timing register. A simple programming path is also modelled. A program command ORs the write-data word into the selected block after a delay set by a write timing register. This path is blocked while the protect bit is set.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset the status register reads 0x04 (standby only), read data reads 0, write timing reads 6, read timing reads 4, debounce control reads 3 and the module-enable register reads 0.
- R2: Register offsets are: protect control 0x00 (bit 0), read data 0x04, write data 0x08 (low 16 bits), block index 0x0C, mode 0x10, status 0x14, write timing 0x20, read timing 0x24, debounce 0x28 and module enable 0x40 (bit 6 only). A bus read returns its value on bus_rdata one cycle after bus_rd.
- R3: Mode bits are command pulses and always read back as zero: bit 0 starts programming, bit 1 starts a read and bit 2 clears read-done. If bits 0 and 1 are written together, the read is taken.
- R4: An accepted read holds read-busy (status bit 1) set and standby (bit 2) clear for N cycles, where N is the read timing value or 2 if that value is smaller. Read-busy then clears, read-done sets, and the addressed word appears in bits 15:0 of read data, with bits 31:16 at zero.
- R5: Read-done (status bit 4) stays set until a clear command is written while the module is enabled.
- R6: A command written while module enable is clear, or a start written while standby is clear, is ignored and leaves status and read data unchanged.
- R7: Status bit positions are: 0 program busy, 1 read busy, 2 standby, 3 protect, 4 read done. All other bits read 0.
- R8: Before any programming, block i holds the low 16 bits of (i*0x0931) XOR 0xC35A.
- R9: An accepted program command holds program-busy set for max(write timing, 2) cycles. After that, the selected block holds its old value ORed with the write-data word.
- R10: While protect is set, a program command is ignored, status bit 3 reads 1 and reads still complete normally.
- R11: Only bits 4:0 of the block index are stored. Higher bits read back as zero and do not affect the block that is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench reads every block at several timing settings. It counts the polls that show read-busy, so a sequencer that is off by one cycle, or that ignores the two-cycle floor, gives the wrong count. It also issues a second start in the middle of a read. A design that re-arms on that start would return the second block instead of the first. The sticky flag is checked after idle cycles and after a clear sent while the module is disabled. A done flag that self-clears, or that obeys a clear while disabled, would read 0 where 1 is expected. Programming is checked with protect clear and with protect set, so an OR that is lost, or a protect bit that is not honoured, shows up as a wrong word on readback.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam logic [7:0] A_PROT  = 8'h00;
  localparam logic [7:0] A_RDATA = 8'h04;
  localparam logic [7:0] A_WDATA = 8'h08;
  localparam logic [7:0] A_INDEX = 8'h0C;
  localparam logic [7:0] A_MODE  = 8'h10;
  localparam logic [7:0] A_STAT  = 8'h14;
  localparam logic [7:0] A_WTIM  = 8'h20;
  localparam logic [7:0] A_RTIM  = 8'h24;
  localparam logic [7:0] A_DEB   = 8'h28;
  localparam logic [7:0] A_MEN   = 8'h40;

  localparam int MB_PROG = 0;
  localparam int MB_READ = 1;
  localparam int MB_CLR  = 2;
  localparam int EN_BIT  = 6;

  typedef enum logic [1:0] {SQ_IDLE, SQ_READ, SQ_PROG} sq_state_t;
endpackage

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int NBLK   = 32,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  addr,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] dout
);
  logic [WORD_W-1:0] mem [NBLK];

  initial begin
    for (int i = 0; i < NBLK; i++)
      mem[i] = WORD_W'((i * 32'h0931) ^ 32'hC35A);
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    dout <= mem[addr];
  end
endmodule

// File: rtl/fuse_regs.sv
module fuse_regs
  import fuse_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int WORD_W = 16,
  parameter int IDX_W  = 5,
  parameter int TIM_W  = 8,
  parameter int WTIM_RST = 6,
  parameter int RTIM_RST = 4,
  parameter int DEB_RST  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              st_pgm_busy,
  input  logic              st_rd_busy,
  input  logic              st_standby,
  input  logic              st_done,
  input  logic [WORD_W-1:0] rd_word,
  output logic [IDX_W-1:0]  blk_idx,
  output logic [WORD_W-1:0] wr_word,
  output logic [TIM_W-1:0]  rd_tim,
  output logic [TIM_W-1:0]  wr_tim,
  output logic              protect,
  output logic              mod_en,
  output logic              cmd_rd,
  output logic              cmd_pg,
  output logic              cmd_clr
);
  logic [TIM_W-1:0]  deb_tim;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_mode;
  logic              unused_wd;

  assign unused_wd = ^bus_wdata;
  assign wr_mode = bus_wr && (bus_addr == ADDR_W'(A_MODE));
  assign cmd_pg  = wr_mode && bus_wdata[MB_PROG];
  assign cmd_rd  = wr_mode && bus_wdata[MB_READ];
  assign cmd_clr = wr_mode && bus_wdata[MB_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      protect <= 1'b0;
      wr_word <= '0;
      blk_idx <= '0;
      wr_tim  <= TIM_W'(WTIM_RST);
      rd_tim  <= TIM_W'(RTIM_RST);
      deb_tim <= TIM_W'(DEB_RST);
      mod_en  <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADDR_W'(A_PROT):  protect <= bus_wdata[0];
        ADDR_W'(A_WDATA): wr_word <= bus_wdata[WORD_W-1:0];
        ADDR_W'(A_INDEX): blk_idx <= bus_wdata[IDX_W-1:0];
        ADDR_W'(A_WTIM):  wr_tim  <= bus_wdata[TIM_W-1:0];
        ADDR_W'(A_RTIM):  rd_tim  <= bus_wdata[TIM_W-1:0];
        ADDR_W'(A_DEB):   deb_tim <= bus_wdata[TIM_W-1:0];
        ADDR_W'(A_MEN):   mod_en  <= bus_wdata[EN_BIT];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(A_PROT):  rd_mux = DATA_W'(protect);
      ADDR_W'(A_RDATA): rd_mux = DATA_W'(rd_word);
      ADDR_W'(A_WDATA): rd_mux = DATA_W'(wr_word);
      ADDR_W'(A_INDEX): rd_mux = DATA_W'(blk_idx);
      ADDR_W'(A_STAT):  rd_mux = DATA_W'({st_done, protect, st_standby, st_rd_busy, st_pgm_busy});
      ADDR_W'(A_WTIM):  rd_mux = DATA_W'(wr_tim);
      ADDR_W'(A_RTIM):  rd_mux = DATA_W'(rd_tim);
      ADDR_W'(A_DEB):   rd_mux = DATA_W'(deb_tim);
      ADDR_W'(A_MEN):   rd_mux = DATA_W'(mod_en) << EN_BIT;
      default:          rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R3
  mode_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(A_MODE)) |=> (bus_rdata == '0));

  // R11
  index_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(A_INDEX)) |=> (bus_rdata[DATA_W-1:IDX_W] == '0));
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 5,
  parameter int TIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_en,
  input  logic              protect,
  input  logic              cmd_rd,
  input  logic              cmd_pg,
  input  logic              cmd_clr,
  input  logic [IDX_W-1:0]  blk_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [TIM_W-1:0]  rd_tim,
  input  logic [TIM_W-1:0]  wr_tim,
  input  logic [WORD_W-1:0] arr_dout,
  output logic [IDX_W-1:0]  arr_addr,
  output logic              arr_we,
  output logic [WORD_W-1:0] arr_wdata,
  output logic              rd_busy,
  output logic              pgm_busy,
  output logic              standby,
  output logic              done,
  output logic [WORD_W-1:0] rd_word
);
  sq_state_t         st;
  logic [TIM_W-1:0]  cnt;
  logic [WORD_W-1:0] wd_q;
  logic              last;
  logic              rd_fin;

  function automatic logic [TIM_W-1:0] floor2(input logic [TIM_W-1:0] t);
    return (t < TIM_W'(2)) ? TIM_W'(2) : t;
  endfunction

  assign last     = (cnt == TIM_W'(1));
  assign rd_fin   = (st == SQ_READ) && last;
  assign rd_busy  = (st == SQ_READ);
  assign pgm_busy = (st == SQ_PROG);
  assign standby  = (st == SQ_IDLE);
  assign arr_we   = (st == SQ_PROG) && last;
  assign arr_wdata = arr_dout | wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      cnt      <= '0;
      arr_addr <= '0;
      wd_q     <= '0;
      rd_word  <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (mod_en && cmd_rd) begin
            st       <= SQ_READ;
            cnt      <= floor2(rd_tim);
            arr_addr <= blk_idx;
          end else if (mod_en && cmd_pg && !protect) begin
            st       <= SQ_PROG;
            cnt      <= floor2(wr_tim);
            arr_addr <= blk_idx;
            wd_q     <= wr_word;
          end
        end
        SQ_READ: begin
          if (last) begin
            rd_word <= arr_dout;
            st      <= SQ_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_PROG: begin
          if (last) st  <= SQ_IDLE;
          else      cnt <= cnt - 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      done <= 1'b0;
    else if (rd_fin)              done <= 1'b1;
    else if (mod_en && cmd_clr)   done <= 1'b0;
  end

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !(mod_en && cmd_clr)) |=> done);

  // R5
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (mod_en && cmd_clr && !rd_busy) |=> !done);

  // R6
  disabled_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (standby && !mod_en) |=> standby);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_busy |=> $stable(rd_word));

  // R10
  protect_chk: assert property (@(posedge clk) disable iff (rst)
    (standby && protect && !cmd_rd) |=> !pgm_busy);

  // R9
  write_only_prog_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !rd_busy && !standby);
endmodule

// File: rtl/fuse_rd_ctrl.sv
module fuse_rd_ctrl #(
  parameter int NBLK   = 32,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int TIM_W  = 8,
  parameter int WTIM_RST = 6,
  parameter int RTIM_RST = 4,
  parameter int DEB_RST  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int IDX_W = $clog2(NBLK);

  logic [IDX_W-1:0]  blk_idx, arr_addr;
  logic [WORD_W-1:0] wr_word, rd_word, arr_dout, arr_wdata;
  logic [TIM_W-1:0]  rd_tim, wr_tim;
  logic protect, mod_en, cmd_rd, cmd_pg, cmd_clr;
  logic rd_busy, pgm_busy, standby, done, arr_we;

  fuse_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W), .IDX_W(IDX_W),
    .TIM_W(TIM_W), .WTIM_RST(WTIM_RST), .RTIM_RST(RTIM_RST), .DEB_RST(DEB_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .st_pgm_busy(pgm_busy), .st_rd_busy(rd_busy), .st_standby(standby),
    .st_done(done), .rd_word(rd_word), .blk_idx(blk_idx), .wr_word(wr_word),
    .rd_tim(rd_tim), .wr_tim(wr_tim), .protect(protect), .mod_en(mod_en),
    .cmd_rd(cmd_rd), .cmd_pg(cmd_pg), .cmd_clr(cmd_clr)
  );

  fuse_seq #(.WORD_W(WORD_W), .IDX_W(IDX_W), .TIM_W(TIM_W)) u_seq (
    .clk(clk), .rst(rst), .mod_en(mod_en), .protect(protect),
    .cmd_rd(cmd_rd), .cmd_pg(cmd_pg), .cmd_clr(cmd_clr), .blk_idx(blk_idx),
    .wr_word(wr_word), .rd_tim(rd_tim), .wr_tim(wr_tim), .arr_dout(arr_dout),
    .arr_addr(arr_addr), .arr_we(arr_we), .arr_wdata(arr_wdata),
    .rd_busy(rd_busy), .pgm_busy(pgm_busy), .standby(standby),
    .done(done), .rd_word(rd_word)
  );

  fuse_array #(.NBLK(NBLK), .WORD_W(WORD_W)) u_array (
    .clk(clk), .addr(arr_addr), .we(arr_we), .wdata(arr_wdata), .dout(arr_dout)
  );
endmodule

// File: tb/fuse_rd_ctrl_test.sv
module fuse_rd_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [15:0] model [32];

  fuse_rd_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge, one cycle each
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  // poll status until bit mask clears; returns number of polls with it set
  task automatic poll_busy(input logic [31:0] mask, output int n);
    logic [31:0] s;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      rd(8'h14, s);
      if ((s & mask) == 0) break;
      n++;
    end
  endtask

  task automatic do_read(input int idx, input int tim, input string req);
    int n;
    logic [31:0] v;
    wr(8'h24, 32'(tim));
    wr(8'h0C, 32'(idx));
    wr(8'h10, 32'h2);
    poll_busy(32'h2, n);
    check({req, " busy cycles"}, 32'(n), 32'((tim < 2) ? 2 : tim));
    rd(8'h14, v);
    check({req, " status after read"}, v, 32'h14);
    rd(8'h04, v);
    check({req, " word"}, v, {16'h0, model[idx & 31]});
    wr(8'h10, 32'h4);
    rd(8'h14, v);
    check({req, " status after clear"}, v, 32'h04);
  endtask

  initial begin
    logic [31:0] v;
    int n;
    for (int i = 0; i < 32; i++) model[i] = 16'((i * 32'h0931) ^ 32'hC35A);
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(8'h14, v); check("R1 status", v, 32'h04);
    rd(8'h04, v); check("R1 rdata", v, 32'h0);
    rd(8'h20, v); check("R1 wtim", v, 32'd6);
    rd(8'h24, v); check("R1 rtim", v, 32'd4);
    rd(8'h28, v); check("R1 deb", v, 32'd3);
    rd(8'h40, v); check("R1 enable", v, 32'h0);

    // R6 start while disabled
    wr(8'h0C, 32'd3);
    wr(8'h10, 32'h2);
    rd(8'h14, v); check("R6 disabled status", v, 32'h04);
    repeat (8) @(negedge clk);
    rd(8'h14, v); check("R6 disabled status late", v, 32'h04);
    rd(8'h04, v); check("R6 disabled rdata", v, 32'h0);

    // R2 enable register only bit 6
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); check("R2 enable readback", v, 32'h40);
    wr(8'h28, 32'd9);
    rd(8'h28, v); check("R2 deb readback", v, 32'd9);

    // R4 R8 R7 sweep of all blocks at varying read timing
    for (int i = 0; i < 32; i++) do_read(i, i % 7, "R4 R8 sweep");

    // R3 mode reads zero after a start
    wr(8'h24, 32'd12);
    wr(8'h0C, 32'd9);
    wr(8'h10, 32'h2);
    rd(8'h10, v); check("R3 mode readback", v, 32'h0);
    rd(8'h14, v); check("R7 read busy bits", v, 32'h02);
    // R6 start while busy ignored
    wr(8'h0C, 32'd10);
    wr(8'h10, 32'h2);
    poll_busy(32'h2, n);
    rd(8'h04, v); check("R6 start while busy word", v, {16'h0, model[9]});

    // R5 sticky done
    repeat (20) @(negedge clk);
    rd(8'h14, v); check("R5 done held", v, 32'h14);
    wr(8'h40, 32'h0);
    wr(8'h10, 32'h4);
    wr(8'h40, 32'h40);
    rd(8'h14, v); check("R5 clear while disabled ignored", v, 32'h14);
    wr(8'h10, 32'h4);
    rd(8'h14, v); check("R5 cleared", v, 32'h04);

    // R11 index masking
    wr(8'h0C, 32'hFFFF_FFE5);
    rd(8'h0C, v); check("R11 index readback", v, 32'h05);
    do_read(32'hFFFF_FFE5 & 31, 3, "R11 masked read");

    // R9 programming
    wr(8'h08, 32'hABCD_0F0F);
    rd(8'h08, v); check("R2 wdata readback", v, 32'h0000_0F0F);
    wr(8'h20, 32'd3);
    wr(8'h0C, 32'd7);
    wr(8'h10, 32'h1);
    poll_busy(32'h1, n);
    check("R9 program busy cycles", 32'(n), 32'd3);
    model[7] = model[7] | 16'h0F0F;
    do_read(7, 2, "R9 programmed word");
    // R3 both start bits: read wins
    wr(8'h08, 32'hFFFF);
    wr(8'h0C, 32'd6);
    wr(8'h10, 32'h3);
    poll_busy(32'h3, n);
    rd(8'h04, v); check("R3 read wins over program", v, {16'h0, model[6]});
    wr(8'h10, 32'h4);
    do_read(6, 2, "R3 block unchanged");

    // R10 protect
    wr(8'h00, 32'h1);
    rd(8'h14, v); check("R10 protect status", v, 32'h0C);
    wr(8'h08, 32'hFFFF);
    wr(8'h0C, 32'd8);
    wr(8'h10, 32'h1);
    rd(8'h14, v); check("R10 program ignored", v, 32'h0C);
    repeat (10) @(negedge clk);
    wr(8'h24, 32'd5);
    wr(8'h10, 32'h2);
    poll_busy(32'h2, n);
    check("R10 read busy while protected", 32'(n), 32'd5);
    rd(8'h04, v); check("R10 block 8 unprogrammed", v, {16'h0, model[8]});
    rd(8'h14, v); check("R10 status done", v, 32'h1C);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule